// File: doc/BRIEF.md
# Predicated Lane Half-Swap Execution Unit

This execution slice belongs to a scalable vector unit. It claims one 32-bit instruction pattern in two forms, a merging form and a zeroing form. For every 128-bit lane that the governing predicate marks active, it exchanges the two 64-bit halves of the source vector. Lanes that are not active take either the old destination contents or zeros, depending on the form. The vector length `VL` is a parameter: a multiple of 128, from 128 to 2048 bits. The predicate supplies one bit per byte of the vector.

The surrounding pipeline reads the register file using the source and predicate selectors that this block decodes from the instruction word. It then presents the source vector, the old destination vector and the predicate value. One cycle after a valid input, the block returns the following:
- a registered result;
- a destination index;
- a write-enable;
- an undefined-instruction flag.

The undefined flag is raised when the form is recognised but neither of the feature enables for that form is set. Instruction words of any other pattern are not claimed: the block raises neither a write nor a flag.

Top module: `lane_halfswap_unit`

## Requirements
- R1: The word is claimed only when `instr[31:14]` equals `000001010010111010`. Any other word gives `out_we=0` and `out_undef=0` in the following cycle.
- R2: `instr[13]` selects the form: 0 is merging and 1 is zeroing.
- R3: In an active lane `e`, the result bits `[128e+63:128e]` equal source bits `[128e+127:128e+64]`, and the result bits `[128e+127:128e+64]` equal source bits `[128e+63:128e]`.
- R4: Lane `e` is active exactly when `pred[16e]` is 1. All other predicate bits have no effect on the result.
- R5: In the merging form, an inactive lane of the result equals the same lane of `dst_old`.
- R6: In the zeroing form, an inactive lane of the result is all zeros.
- R7: The merging form is legal when `feat_m_a` or `feat_m_b` is set. The zeroing form is legal when `feat_z_a` or `feat_z_b` is set. A claimed word of an illegal form gives `out_undef=1` and `out_we=0`.
- R8: The outputs `out_valid`, `out_we`, `out_undef`, `out_result` and `out_dst_idx` reflect the input of the previous clock cycle.
  - `out_valid` follows `in_valid`.
  - `out_dst_idx` equals `instr[4:0]`.
  - `out_we` and `out_undef` are never both high.
- R9: The decode outputs are combinational: `src_sel` equals `instr[9:5]` and `pred_sel` equals `instr[12:10]`.
- R10: While `rst_n` is low, `out_valid`, `out_we`, `out_undef`, `out_dst_idx` and `out_result` are zero.
- R11: A cycle with `in_valid=0` gives `out_valid=0`, `out_we=0` and `out_undef=0` in the following cycle, whatever the instruction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input operands and instruction are valid |
| instr | input | 32 | Instruction word |
| feat_m_a | input | 1 | First feature enable for the merging form |
| feat_m_b | input | 1 | Second feature enable for the merging form |
| feat_z_a | input | 1 | First feature enable for the zeroing form |
| feat_z_b | input | 1 | Second feature enable for the zeroing form |
| src_vec | input | VL | Source vector value |
| dst_old | input | VL | Prior destination vector value |
| pred | input | VL/8 | Governing predicate value |
| src_sel | output | 5 | Decoded source register index |
| pred_sel | output | 3 | Decoded predicate register index |
| out_valid | output | 1 | Registered valid |
| out_we | output | 1 | Destination write-enable |
| out_undef | output | 1 | Undefined-instruction flag |
| out_dst_idx | output | 5 | Destination register index |
| out_result | output | VL | Result vector |

## Verification
The hardest case to reach from the ports is a predicate whose bits are mostly ones, with only the lowest bit of each lane's group cleared. In that case a design that looks at the wrong bit, or ORs over the whole group, would treat every lane as active. The stimulus table includes such predicates in the merging form, together with all-ones and all-zero predicates in the zeroing form. Each word of the table is paired with a feature-enable mix that turns the same opcode legal in one row and undefined in another. This separates the form-select bit from the feature gating.

// File: rtl/lane_halfswap_unit.sv
module lane_halfswap_unit #(
  parameter int VL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic              feat_m_a,
  input  logic              feat_m_b,
  input  logic              feat_z_a,
  input  logic              feat_z_b,
  input  logic [VL-1:0]     src_vec,
  input  logic [VL-1:0]     dst_old,
  input  logic [VL/8-1:0]   pred,
  output logic [4:0]        src_sel,
  output logic [2:0]        pred_sel,
  output logic              out_valid,
  output logic              out_we,
  output logic              out_undef,
  output logic [4:0]        out_dst_idx,
  output logic [VL-1:0]     out_result
);
  localparam int LANES = VL / 128;
  localparam int PGRP  = 16;
  localparam logic [17:0] OPC_HI = 18'b000001010010111010;

  logic             hit, zmode, legal, any_act;
  logic [LANES-1:0] act;
  logic [VL-1:0]    opnd, res;
  logic             unused_pred;

  assign hit      = (instr[31:14] == OPC_HI);
  assign zmode    = instr[13];
  assign legal    = zmode ? (feat_z_a | feat_z_b) : (feat_m_a | feat_m_b);
  assign src_sel  = instr[9:5];
  assign pred_sel = instr[12:10];
  assign unused_pred = ^pred;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    assign act[e] = pred[PGRP*e];
    assign res[128*e +: 128] = act[e] ? {opnd[128*e +: 64], opnd[128*e+64 +: 64]}
                             : (zmode ? 128'b0 : dst_old[128*e +: 128]);
  end

  assign any_act = |act;
  assign opnd    = any_act ? src_vec : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_we      <= 1'b0;
      out_undef   <= 1'b0;
      out_dst_idx <= '0;
      out_result  <= '0;
    end else begin
      out_valid <= in_valid;
      out_we    <= in_valid & hit & legal;
      out_undef <= in_valid & hit & ~legal;
      if (in_valid) begin
        out_dst_idx <= instr[4:0];
        out_result  <= res;
      end
    end
  end
endmodule

// File: rtl/lane_halfswap_unit_chk.sv
module lane_halfswap_unit_chk #(
  parameter int VL = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [31:0]     instr,
  input logic            feat_m_a,
  input logic            feat_m_b,
  input logic            feat_z_a,
  input logic            feat_z_b,
  input logic [VL-1:0]   src_vec,
  input logic [VL-1:0]   dst_old,
  input logic [VL/8-1:0] pred,
  input logic            out_valid,
  input logic            out_we,
  input logic            out_undef,
  input logic [4:0]      out_dst_idx,
  input logic [VL-1:0]   out_result
);
  logic claim, m_ok, z_ok;
  assign claim = (instr[31:14] == 18'b000001010010111010);
  assign m_ok  = feat_m_a | feat_m_b;
  assign z_ok  = feat_z_a | feat_z_b;

  // R1
  no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !claim) |=> (!out_we && !out_undef));

  // R7
  undef_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && claim && !(instr[13] ? z_ok : m_ok)) |=> (out_undef && !out_we));

  // R8
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_we && out_undef));

  // R8
  dst_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_dst_idx == $past(instr[4:0])));

  // R11
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_we && !out_undef));

  // R3
  lane0_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && claim && !instr[13] && m_ok) |=>
      (out_result[63:0] == ($past(pred[0]) ? $past(src_vec[127:64]) : $past(dst_old[63:0]))));

  // R6
  zero_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && claim && instr[13] && z_ok && pred == '0) |=> (out_result == '0));
endmodule

bind lane_halfswap_unit lane_halfswap_unit_chk #(.VL(VL)) chk_i (.*);

// File: tb/lane_halfswap_unit_tb_top.sv
`timescale 1ns/1ps
module lane_halfswap_unit_tb_top;
  localparam int VL = 256;
  localparam int PW = VL / 8;
  localparam int LANES = VL / 128;
  localparam int N = 10;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] instr = '0;
  logic feat_m_a = 0, feat_m_b = 0, feat_z_a = 0, feat_z_b = 0;
  logic [VL-1:0] src_vec = '0, dst_old = '0;
  logic [PW-1:0] pred = '0;
  logic [4:0] src_sel, out_dst_idx;
  logic [2:0] pred_sel;
  logic out_valid, out_we, out_undef;
  logic [VL-1:0] out_result;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  lane_halfswap_unit #(.VL(VL)) dut_i (.*);

  // mode, pg, zn, zd packed as {valid-pattern selector} via words below
  localparam logic [31:0] T_INSTR [N] = '{
    32'h052E_8000 | (3 << 10) | (5 << 5) | 7,
    32'h052E_8000 | (1 << 10) | (2 << 5) | 9,
    32'h052E_8000 | (7 << 10) | (31 << 5) | 31,
    32'h052E_A000 | (2 << 10) | (4 << 5) | 1,
    32'h052E_A000 | (0 << 10) | (6 << 5) | 2,
    32'h052E_A000 | (5 << 10) | (8 << 5) | 3,
    32'h052E_8000 | (4 << 10) | (9 << 5) | 4,
    32'h052E_A000 | (6 << 10) | (10 << 5) | 5,
    32'h052F_8000 | 6,
    32'h0000_0000
  };
  localparam logic [PW-1:0] T_PRED [N] = '{
    32'h0001_0001, 32'h0000_0001, 32'hFFFE_FFFE, 32'h0001_0000, 32'h0000_0000,
    32'hFFFF_FFFF, 32'h0001_0001, 32'h0001_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF
  };
  // bit0 feat_m_a, bit1 feat_m_b, bit2 feat_z_a, bit3 feat_z_b
  localparam logic [3:0] T_FEAT [N] = '{
    4'b0001, 4'b0010, 4'b0001, 4'b0100, 4'b1000,
    4'b0100, 4'b1100, 4'b0011, 4'b1111, 4'b1111
  };

  task automatic chk(input bit ok, input string tag, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [VL-1:0] mkvec(input int seed);
    logic [VL-1:0] v;
    for (int w = 0; w < VL/32; w++)
      v[32*w +: 32] = (32'h9E37_79B9 * (w + 1)) ^ (32'h0101_0101 * seed) ^ 32'h5A00_00A5;
    return v;
  endfunction

  function automatic logic [VL-1:0] model(input logic [31:0] ins, input logic [VL-1:0] s,
                                          input logic [VL-1:0] d, input logic [PW-1:0] p);
    logic [VL-1:0] r;
    for (int e = 0; e < LANES; e++) begin
      if (p[16*e]) begin
        r[128*e +: 64]    = s[128*e+64 +: 64];
        r[128*e+64 +: 64] = s[128*e +: 64];
      end else begin
        r[128*e +: 128] = ins[13] ? '0 : d[128*e +: 128];
      end
    end
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog R8 actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [VL-1:0] s, d, exp_r;
    bit claim, legal;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!out_valid && !out_we && !out_undef && out_dst_idx == 0, "R10 flags",
        {out_valid, out_we, out_undef, out_dst_idx}, '0);
    chk(out_result == '0, "R10 result", out_result, '0);
    rst_n = 1;

    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      s = mkvec(i + 1);
      d = mkvec(i + 40);
      instr = T_INSTR[i]; pred = T_PRED[i];
      {feat_z_b, feat_z_a, feat_m_b, feat_m_a} = T_FEAT[i];
      src_vec = s; dst_old = d; in_valid = 1;
      #1;
      chk(src_sel == instr[9:5] && pred_sel == instr[12:10], "R9 decode",
          {src_sel, pred_sel}, {instr[9:5], instr[12:10]});
      claim = (instr[31:14] == 18'b000001010010111010);
      legal = instr[13] ? (T_FEAT[i][2] | T_FEAT[i][3]) : (T_FEAT[i][0] | T_FEAT[i][1]);
      exp_r = model(instr, s, d, pred);
      @(negedge clk);
      in_valid = 0;
      chk(out_valid == 1'b1, "R8 valid", out_valid, 1);
      chk(out_we == (claim && legal), "R1 R7 write-enable", out_we, claim && legal);
      chk(out_undef == (claim && !legal), "R1 R7 undef", out_undef, claim && !legal);
      if (claim) chk(out_dst_idx == instr[4:0], "R8 dst index", out_dst_idx, instr[4:0]);
      if (claim && legal)
        chk(out_result == exp_r, instr[13] ? "R2 R3 R4 R6 result" : "R2 R3 R4 R5 result",
            out_result, exp_r);
    end

    // R11: legal word with in_valid low
    @(negedge clk);
    instr = T_INSTR[0]; {feat_z_b, feat_z_a, feat_m_b, feat_m_a} = 4'b1111; in_valid = 0;
    @(negedge clk);
    chk(!out_valid && !out_we && !out_undef, "R11 idle",
        {out_valid, out_we, out_undef}, '0);

    // R10: reset reasserted after activity
    in_valid = 1;
    @(negedge clk);
    in_valid = 0; rst_n = 0;
    @(negedge clk);
    chk(!out_valid && !out_we && out_result == '0, "R10 re-reset", out_result, '0);
    rst_n = 1;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule